// File: doc/BRIEF.md
# SPI Command and Register Slave

This block sits behind a host serial port and turns framed 16-bit SPI traffic into register updates, command strobes, a sweep-point configuration write and read-back of status, result and ADC-limit data. A transaction is everything between chip-select going low and going high again. The first word of each transaction carries a three-bit opcode in its top bits. That opcode fixes how many words follow and whether they carry data into the block or out of it.

The bus runs in SPI mode 0, most significant bit first. SCLK, chip-select and MOSI are brought into the core clock domain through two-flop synchronisers, so SCLK must be slower than about a quarter of the core clock. The response word for each slot is already on MISO before the first rising SCLK edge of that slot. Slot 0 of every frame returns the status word.

The sweep-point write port is a stream output with no back-pressure. The SPI host cannot be stalled, so `cfg_valid` is a single-cycle pulse, the sink must accept it in that cycle, and no ready input exists. The sweep engine, the ADC limit tracker and the accumulators are outside this block and appear only as inputs.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset every register output and `result_ready` are zero. While chip-select is high, MISO is driven low.
- R2: A first word with top bits `100` is a register write. Its low three bits select one of five registers: 0 system control, 1 point count, 2 samples per point, 3 settling time, 4 interrupt mask. The second word is the data, and it is committed when that word completes. Addresses 5 to 7, and frames that end after the header, change no register.
- R3: A first word with top bits `010` returns status in slot 0 and the constant 0xF0A5 in slot 1.
- R4: The status word equals `stat_misc`, except that bit 2 is the result-ready flag and bit 4 is `sweep_halted`. Both values are taken when chip-select falls.
- R5: A first word with top bits `110` returns status in slot 0. If the ready flag was set when chip-select fell, slots 1 to 18 carry `res_bus[16*(k-1) +: 16]` for slot k. The six 48-bit values are packed lowest first (RefQ, RefI, P2Q, P2I, P1Q, P1I), each least significant word first. If the flag was clear, those slots are zero.
- R6: A `res_new` pulse sets the ready flag. Completing all 18 result slots clears it. A result frame that ends early leaves it set. If a set and a clear happen in the same cycle, the set wins.
- R7: A first word with top bits `111` returns `lim_bus[16*(k-1) +: 16]` in slots 1 to 6.
- R8: A first word with top bits `011` produces exactly one cycle of `lim_clr`. Top bits `001` produce exactly one cycle of `resume`. Each pulse follows completion of the first word.
- R9: A first word with top bits `000` is a sweep-point write. Its low 13 bits give `cfg_index`. After the seventh following word completes, `cfg_valid` pulses once, with data word j on `cfg_data[16*j +: 16]`. From data word 0, bit 15 drives `cfg_halt`, bit 14 drives `cfg_lowband` and bits 10:9 drive `cfg_filter`. A shorter frame produces no pulse.
- R10: Top bits `101` are reserved. They produce no strobe and no register change, and every slot after slot 0 returns zero.
- R11: Slots beyond the length defined for an opcode return zero and trigger nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| stat_misc | input | 16 | Status bits other than 2 and 4 |
| sweep_halted | input | 1 | Sweep halted, reported in status bit 4 |
| res_new | input | 1 | Pulse: a new result set is available |
| res_bus | input | 288 | Six 48-bit results, RefQ in the low bits |
| lim_bus | input | 96 | ADC limit data, six words |
| regs_o | output | 80 | Five 16-bit registers, register n at bits 16n+15:16n |
| lim_clr | output | 1 | ADC-limit reset strobe |
| resume | output | 1 | Resume-halted-sweep strobe |
| cfg_valid | output | 1 | Sweep-point write valid, one cycle |
| cfg_index | output | 13 | Sweep-point index |
| cfg_data | output | 112 | Seven configuration words |
| cfg_halt | output | 1 | Per-point halt flag |
| cfg_lowband | output | 1 | Low-band flag |
| cfg_filter | output | 2 | Lowpass filter select |
| result_ready | output | 1 | Result-ready flag |

## Verification
A word counter that is off by one shows up in the first read-back slot after the header. The result frame is the most exposed case: a shifted counter moves every one of its 18 words, and the next status word shows the ready flag wrongly cleared or wrongly still set. A wrong opcode latch shows up as a missing or extra strobe, or as an unchanged register, within a couple of cycles of the word that should have acted. Because the bench samples each MISO bit just before the SCLK rise, a response loaded late is seen as a wrong top bit in that very slot.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [2:0] {
    OP_CFG    = 3'b000,
    OP_RESUME = 3'b001,
    OP_STAT   = 3'b010,
    OP_LIMCLR = 3'b011,
    OP_WRREG  = 3'b100,
    OP_RSVD   = 3'b101,
    OP_RESULT = 3'b110,
    OP_LIMITS = 3'b111
  } op_e;

  localparam logic [15:0] ID_WORD = 16'hF0A5;
  localparam int RDY_BIT  = 2;
  localparam int HALT_BIT = 4;
endpackage

// File: rtl/spi_word_port.sv
module spi_word_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic [W-1:0] tx_first,
  input  logic [W-1:0] tx_next,
  output logic         miso,
  output logic         active,
  output logic         frame_start,
  output logic         word_done,
  output logic [W-1:0] rx_word
);
  localparam int BW = $clog2(W);

  logic [1:0]    s_sclk, s_cs, s_mosi;
  logic          sclk_d, active_q;
  logic [BW-1:0] bcnt;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          rise, fall;

  assign active      = ~s_cs[1];
  assign frame_start = active & ~active_q;
  assign rise        = s_sclk[1] & ~sclk_d;
  assign fall        = ~s_sclk[1] & sclk_d;
  assign miso        = tx_sh[W-1] & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sclk   <= '0;
      s_cs     <= 2'b11;
      s_mosi   <= '0;
      sclk_d   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      s_sclk   <= {s_sclk[0], sclk};
      s_cs     <= {s_cs[0], cs_n};
      s_mosi   <= {s_mosi[0], mosi};
      sclk_d   <= s_sclk[1];
      active_q <= active;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_word   <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (!active) begin
        bcnt  <= '0;
        tx_sh <= '0;
      end else if (frame_start) begin
        bcnt  <= '0;
        tx_sh <= tx_first;
      end else if (rise) begin
        rx_sh <= {rx_sh[W-2:0], s_mosi[1]};
        if (bcnt == BW'(W-1)) begin
          bcnt      <= '0;
          word_done <= 1'b1;
          rx_word   <= {rx_sh[W-2:0], s_mosi[1]};
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end else if (fall) begin
        if (bcnt == '0) tx_sh <= tx_next;
        else            tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int W         = 16,
  parameter int AW        = 3,
  parameter int IDXW      = 13,
  parameter int CFG_WORDS = 7,
  parameter int RES_WORDS = 18,
  parameter int LIM_WORDS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   frame_start,
  input  logic                   word_done,
  input  logic [W-1:0]           rx_word,
  input  logic [W-1:0]           stat_misc,
  input  logic                   sweep_halted,
  input  logic                   res_new,
  input  logic [RES_WORDS*W-1:0] res_bus,
  input  logic [LIM_WORDS*W-1:0] lim_bus,
  output logic [W-1:0]           tx_first,
  output logic [W-1:0]           tx_next,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [W-1:0]           wr_data,
  output logic                   lim_clr,
  output logic                   resume,
  output logic                   cfg_valid,
  output logic [IDXW-1:0]        cfg_index,
  output logic [CFG_WORDS*W-1:0] cfg_data,
  output logic                   ready_flag
);
  localparam int CNTW = $clog2(RES_WORDS + 2);

  op_e             op;
  logic [IDXW-1:0] hdr;
  logic [CNTW-1:0] wcnt, widx;
  logic            lat_rdy, clr_rdy;
  op_e             op_in;

  assign op_in     = op_e'(rx_word[W-1:W-3]);
  assign widx      = wcnt - 1'b1;
  assign wr_addr   = hdr[AW-1:0];
  assign cfg_index = hdr;
  assign clr_rdy   = active && word_done && op == OP_RESULT && lat_rdy &&
                     wcnt == CNTW'(RES_WORDS);

  always_comb begin
    tx_first           = stat_misc;
    tx_first[RDY_BIT]  = ready_flag;
    tx_first[HALT_BIT] = sweep_halted;
  end

  always_comb begin
    tx_next = '0;
    case (op)
      OP_STAT:   if (wcnt == CNTW'(1)) tx_next = ID_WORD;
      OP_RESULT: if (lat_rdy)
                   for (int k = 0; k < RES_WORDS; k++)
                     if (wcnt != '0 && widx == CNTW'(k)) tx_next = res_bus[k*W +: W];
      OP_LIMITS: for (int k = 0; k < LIM_WORDS; k++)
                   if (wcnt != '0 && widx == CNTW'(k)) tx_next = lim_bus[k*W +: W];
      default:   tx_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op         <= OP_RSVD;
      hdr        <= '0;
      wcnt       <= '0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      lim_clr    <= 1'b0;
      resume     <= 1'b0;
      cfg_valid  <= 1'b0;
      cfg_data   <= '0;
      lat_rdy    <= 1'b0;
      ready_flag <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      lim_clr   <= 1'b0;
      resume    <= 1'b0;
      cfg_valid <= 1'b0;
      if (frame_start) lat_rdy <= ready_flag;
      if (res_new)      ready_flag <= 1'b1;
      else if (clr_rdy) ready_flag <= 1'b0;
      if (!active) begin
        wcnt <= '0;
      end else if (word_done) begin
        if (wcnt != '1) wcnt <= wcnt + 1'b1;
        if (wcnt == '0) begin
          op      <= op_in;
          hdr     <= rx_word[IDXW-1:0];
          lim_clr <= (op_in == OP_LIMCLR);
          resume  <= (op_in == OP_RESUME);
        end else begin
          if (op == OP_WRREG && wcnt == CNTW'(1)) begin
            wr_en   <= 1'b1;
            wr_data <= rx_word;
          end
          if (op == OP_CFG) begin
            for (int k = 0; k < CFG_WORDS; k++)
              if (wcnt == CNTW'(k + 1)) cfg_data[k*W +: W] <= rx_word;
            cfg_valid <= (wcnt == CNTW'(CFG_WORDS));
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int W    = 16,
  parameter int NREG = 5,
  parameter int AW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [NREG*W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            regs_o[g*W +: W] <= '0;
      else if (wr_en && wr_addr == AW'(g))   regs_o[g*W +: W] <= wr_data;
    end
  end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int W         = 16,
  parameter int NREG      = 5,
  parameter int IDXW      = 13,
  parameter int CFG_WORDS = 7,
  parameter int RES_WORDS = 18,
  parameter int LIM_WORDS = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sclk,
  input  logic                   spi_cs_n,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  input  logic [W-1:0]           stat_misc,
  input  logic                   sweep_halted,
  input  logic                   res_new,
  input  logic [RES_WORDS*W-1:0] res_bus,
  input  logic [LIM_WORDS*W-1:0] lim_bus,
  output logic [NREG*W-1:0]      regs_o,
  output logic                   lim_clr,
  output logic                   resume,
  output logic                   cfg_valid,
  output logic [IDXW-1:0]        cfg_index,
  output logic [CFG_WORDS*W-1:0] cfg_data,
  output logic                   cfg_halt,
  output logic                   cfg_lowband,
  output logic [1:0]             cfg_filter,
  output logic                   result_ready
);
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

  logic          active, frame_start, word_done, wr_en;
  logic [W-1:0]  rx_word, tx_first, tx_next, wr_data;
  logic [AW-1:0] wr_addr;

  assign cfg_halt    = cfg_data[15];
  assign cfg_lowband = cfg_data[14];
  assign cfg_filter  = cfg_data[10:9];

  spi_word_port #(.W(W)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_first(tx_first), .tx_next(tx_next), .miso(spi_miso), .active(active),
    .frame_start(frame_start), .word_done(word_done), .rx_word(rx_word)
  );

  spi_cmd_seq #(
    .W(W), .AW(AW), .IDXW(IDXW), .CFG_WORDS(CFG_WORDS),
    .RES_WORDS(RES_WORDS), .LIM_WORDS(LIM_WORDS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .frame_start(frame_start),
    .word_done(word_done), .rx_word(rx_word), .stat_misc(stat_misc),
    .sweep_halted(sweep_halted), .res_new(res_new), .res_bus(res_bus),
    .lim_bus(lim_bus), .tx_first(tx_first), .tx_next(tx_next), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .lim_clr(lim_clr), .resume(resume),
    .cfg_valid(cfg_valid), .cfg_index(cfg_index), .cfg_data(cfg_data),
    .ready_flag(result_ready)
  );

  spi_reg_bank #(.W(W), .NREG(NREG), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
  parameter int RW = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso,
  input logic          lim_clr,
  input logic          resume,
  input logic          cfg_valid,
  input logic          res_new,
  input logic          result_ready,
  input logic          word_done,
  input logic [RW-1:0] regs_o
);
  // R1
  idle_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);
  // R2
  reg_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(word_done, 2));
  // R8
  lim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_clr |=> !lim_clr);
  // R8
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  // R9
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> !cfg_valid);
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(result_ready) |-> $past(res_new));
  // R6
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(result_ready) |-> $past(word_done));
endmodule

bind spi_cmd_slave spi_cmd_chk #(.RW(NREG*W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .lim_clr(lim_clr), .resume(resume), .cfg_valid(cfg_valid), .res_new(res_new),
  .result_ready(result_ready), .word_done(word_done), .regs_o(regs_o)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
  logic [15:0]  stat_misc = 16'h0000;
  logic         sweep_halted = 1'b0, res_new = 1'b0;
  logic [287:0] res_bus;
  logic [95:0]  lim_bus;
  logic [79:0]  regs_o;
  logic         lim_clr, resume, cfg_valid, cfg_halt, cfg_lowband, result_ready;
  logic [12:0]  cfg_index;
  logic [111:0] cfg_data;
  logic [1:0]   cfg_filter;

  always #5 clk = ~clk;

  spi_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .stat_misc(stat_misc),
    .sweep_halted(sweep_halted), .res_new(res_new), .res_bus(res_bus),
    .lim_bus(lim_bus), .regs_o(regs_o), .lim_clr(lim_clr), .resume(resume),
    .cfg_valid(cfg_valid), .cfg_index(cfg_index), .cfg_data(cfg_data),
    .cfg_halt(cfg_halt), .cfg_lowband(cfg_lowband), .cfg_filter(cfg_filter),
    .result_ready(result_ready)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  int n_lim = 0, n_res = 0, n_cfg = 0;
  logic [111:0] cap_data;
  logic [12:0]  cap_idx;
  logic [3:0]   cap_flags;

  always @(posedge clk) begin
    if (lim_clr) n_lim++;
    if (resume)  n_res++;
    if (cfg_valid) begin
      n_cfg++;
      cap_data  = cfg_data;
      cap_idx   = cfg_index;
      cap_flags = {cfg_halt, cfg_lowband, cfg_filter};
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // scoreboard for MISO words
  logic [15:0] exp_v[$];
  bit          exp_c[$];
  string       exp_t[$];
  logic [15:0] got_w;
  event        word_ev;

  initial forever begin
    @(word_ev);
    if (exp_v.size() > 0) begin
      logic [15:0] e;
      bit c;
      string t;
      e = exp_v.pop_front();
      c = exp_c.pop_front();
      t = exp_t.pop_front();
      if (c) chk(t, {16'h0, got_w}, {16'h0, e});
    end
  end

  task automatic spi_word(logic [15:0] tx, bit care, logic [15:0] exp, string tag);
    exp_v.push_back(exp);
    exp_c.push_back(care);
    exp_t.push_back(tag);
    for (int i = 15; i >= 0; i--) begin
      spi_mosi = tx[i];
      repeat (HP) @(negedge clk);
      got_w[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HP) @(negedge clk);
      spi_sclk = 1'b0;
    end
    -> word_ev;
  endtask

  task automatic cs_begin();
    spi_cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HP) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  function automatic logic [15:0] status(logic [15:0] misc, logic halt, logic rdy);
    logic [15:0] s;
    s = misc;
    s[4] = halt;
    s[2] = rdy;
    return s;
  endfunction

  task automatic wr_reg(logic [15:0] addr, logic [15:0] data);
    cs_begin();
    spi_word(16'h8000 | addr, 0, 0, "R2");
    spi_word(data, 1, 0, "R11");
    cs_end();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 18; k++) res_bus[k*16 +: 16] = 16'h1000 * (k % 16) + 16'h0100 + 16'(k);
    for (int k = 0; k < 6; k++)  lim_bus[k*16 +: 16] = 16'hA000 + 16'(k * 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 regs", 32'(regs_o[31:0] | regs_o[63:32] | 32'(regs_o[79:64])), 0);
    chk("R1 miso", {31'h0, spi_miso}, 0);
    chk("R1 ready", {31'h0, result_ready}, 0);

    // R2 writes
    wr_reg(1, 16'h1234);
    wr_reg(4, 16'hBEEF);
    wr_reg(0, 16'h0003);
    chk("R2 reg1", {16'h0, regs_o[16 +: 16]}, 32'h1234);
    chk("R2 reg4", {16'h0, regs_o[64 +: 16]}, 32'hBEEF);
    chk("R2 reg0", {16'h0, regs_o[0 +: 16]}, 32'h0003);
    wr_reg(5, 16'h5555);
    cs_begin(); spi_word(16'h8002, 0, 0, "R2"); cs_end();
    chk("R2 bad addr/abort", 32'(regs_o[47:32]) ^ 32'(regs_o[79:64]), 32'hBEEF);
    chk("R2 reg2 untouched", {16'h0, regs_o[32 +: 16]}, 0);

    // R3 / R4 status and identity
    stat_misc = 16'hA5FF; sweep_halted = 1'b1;
    cs_begin();
    spi_word(16'h4000, 1, status(16'hA5FF, 1, 0), "R4 status");
    spi_word(16'h0000, 1, 16'hF0A5, "R3 ident");
    spi_word(16'h0000, 1, 16'h0000, "R11 extra slot");
    cs_end();
    sweep_halted = 1'b0;

    // R5 result read while not ready
    cs_begin();
    spi_word(16'hC000, 1, status(16'hA5FF, 0, 0), "R5 status");
    spi_word(0, 1, 0, "R5 no data");
    spi_word(0, 1, 0, "R5 no data");
    cs_end();

    // R6 set flag, full read clears
    @(negedge clk); res_new = 1'b1; @(negedge clk); res_new = 1'b0;
    chk("R6 set", {31'h0, result_ready}, 1);
    cs_begin();
    spi_word(16'hC000, 1, status(16'hA5FF, 0, 1), "R5 status ready");
    for (int k = 0; k < 18; k++) spi_word(0, 1, res_bus[k*16 +: 16], "R5 result word");
    cs_end();
    chk("R6 cleared", {31'h0, result_ready}, 0);

    // R6 aborted read keeps flag
    @(negedge clk); res_new = 1'b1; @(negedge clk); res_new = 1'b0;
    cs_begin();
    spi_word(16'hC000, 1, status(16'hA5FF, 0, 1), "R6 status");
    for (int k = 0; k < 5; k++) spi_word(0, 1, res_bus[k*16 +: 16], "R5 partial");
    cs_end();
    chk("R6 abort keeps", {31'h0, result_ready}, 1);

    // R7 limits
    cs_begin();
    spi_word(16'hE000, 0, 0, "R7");
    for (int k = 0; k < 6; k++) spi_word(0, 1, lim_bus[k*16 +: 16], "R7 limit word");
    spi_word(0, 1, 0, "R11 past limits");
    cs_end();

    // R8 strobes
    n_lim = 0; n_res = 0;
    cs_begin(); spi_word(16'h6000, 0, 0, "R8"); cs_end();
    chk("R8 lim_clr count", n_lim, 1);
    chk("R8 resume idle", n_res, 0);
    cs_begin(); spi_word(16'h2000, 0, 0, "R8"); spi_word(0, 0, 0, "R11"); cs_end();
    chk("R8 resume count", n_res, 1);
    chk("R8 lim_clr once", n_lim, 1);

    // R9 sweep-point write
    n_cfg = 0;
    cs_begin();
    spi_word(16'h0ABC, 0, 0, "R9");
    spi_word(16'hC400, 0, 0, "R9");
    for (int k = 1; k < 7; k++) spi_word(16'h1111 * 16'(k), 0, 0, "R9");
    cs_end();
    chk("R9 valid count", n_cfg, 1);
    chk("R9 index", {19'h0, cap_idx}, 32'h0ABC);
    chk("R9 flags", {28'h0, cap_flags}, 32'hE);
    chk("R9 word0", {16'h0, cap_data[15:0]}, 32'hC400);
    for (int k = 1; k < 7; k++) chk("R9 data word", {16'h0, cap_data[k*16 +: 16]}, {16'h0, 16'h1111 * 16'(k)});
    cs_begin();
    spi_word(16'h0005, 0, 0, "R9");
    for (int k = 0; k < 3; k++) spi_word(16'h7777, 0, 0, "R9");
    cs_end();
    chk("R9 short frame", n_cfg, 1);

    // R10 reserved opcode
    n_lim = 0; n_res = 0;
    cs_begin();
    spi_word(16'hA001, 1, status(16'hA5FF, 0, 1), "R10 status");
    for (int k = 0; k < 3; k++) spi_word(16'hFFFF, 1, 0, "R10 zero slot");
    cs_end();
    chk("R10 strobes", n_lim + n_res + n_cfg, 1);
    chk("R10 reg1 kept", {16'h0, regs_o[16 +: 16]}, 32'h1234);
    chk("R1 idle miso", {31'h0, spi_miso}, 0);

    finish_run();
  end
endmodule